// File: doc/BRIEF.md
# Byte Queue Pair with Configuration Register and Receive Idle Timer

This block sits between the host register interface of a serial port and its bit-level transmitter and receiver. It keeps two byte queues: one collects bytes the receiver delivers until the host reads them, and the other collects bytes the host writes until the transmitter takes them. An eight-bit configuration register turns queueing on or off, selects the receive threshold reported to the interrupt logic, carries a DMA-style mode flag, and offers two self-clearing bits that empty one queue or the other.

A receive idle timer counts character-time ticks supplied from outside. When receive data has been waiting untouched for a fixed number of character times, the block raises an idle indication that the interrupt logic can report. Bit serialization and interrupt prioritization stay outside the block.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After synchronous reset both queue counts are 0, the stored configuration reads 0x00, the threshold output is 1, and the idle indication, ready flag and both overflow flags are 0.
- R2: Each queue holds up to DEPTH (16) bytes and returns them in the order written, including after its internal pointers wrap past the last slot.
- R3: A push into a full queue is dropped: the count and contents do not change, and that queue's overflow flag is 1 for exactly the one cycle after the push.
- R4: Popping an empty queue presents 0x00 on its data output and leaves the count at 0.
- R5: A configuration write stores the written value ANDed with 0xC9; bit 0 is the queue enable (read out on `fifo_en`) and bit 3 the DMA mode flag (read out on `dma_mode`).
- R6: Stored bits 7:6 select the receive threshold: code 0 gives 1, code 1 gives 4, code 2 gives 8, code 3 gives 14 bytes.
- R7: Writing bit 1 set empties the receive queue and writing bit 2 set empties the transmit queue; neither bit is retained.
- R8: A configuration write whose bit 0 differs from the stored enable empties both queues, whatever bits 1 and 2 hold.
- R9: While the enable is 0, each queue holds at most one byte; a second push is dropped as in R3.
- R10: With the enable set, an accepted receive push starts the idle timer; after TIMEOUT_CHARS (4) further character ticks with data still queued, `rx_timeout` rises, and not after fewer ticks.
- R11: A host read of the receive queue clears `rx_timeout`; if bytes remain after the read the timer restarts from zero, and if the queue became empty the timer stops.
- R12: Emptying the receive queue through the configuration register stops the idle timer and clears `rx_timeout`.
- R13: `rx_ready` is 1 exactly when the receive queue holds at least one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Stored configuration value |
| fifo_en | output | 1 | Queue enable bit |
| dma_mode | output | 1 | DMA mode flag |
| trig_level | output | 5 | Receive threshold in bytes |
| rx_push | input | 1 | Receiver delivers a byte |
| rx_push_data | input | 8 | Received byte |
| rx_overrun | output | 1 | One-cycle flag: receive push dropped |
| host_rd | input | 1 | Host reads the receive buffer |
| host_rd_data | output | 8 | Oldest received byte, 0x00 if empty |
| rx_count | output | 5 | Bytes in the receive queue |
| rx_ready | output | 1 | Receive queue not empty |
| host_wr | input | 1 | Host writes the holding register |
| host_wr_data | input | 8 | Byte to transmit |
| tx_overrun | output | 1 | One-cycle flag: transmit push dropped |
| tx_pop | input | 1 | Transmitter takes a byte |
| tx_pop_data | output | 8 | Oldest byte to transmit, 0x00 if empty |
| tx_count | output | 5 | Bytes in the transmit queue |
| char_tick | input | 1 | One pulse per character time |
| rx_timeout | output | 1 | Receive idle indication |

## Verification
The bench builds the block at its defaults, DEPTH of 16 and TIMEOUT_CHARS of 4, so both queues can be filled to the brim, overfilled, drained and refilled across a pointer wrap in a few dozen cycles each, and every idle window is short enough to step tick by tick on both sides of the expiry. Because the configuration register is only eight bits wide, the bench writes all 256 values in turn, with a byte pushed into each queue before every write, and checks the stored value, the threshold and both counts against an arithmetic model of masking, toggle flush and one-byte capacity.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    localparam int unsigned CFG_W = 8;
    localparam logic [CFG_W-1:0] CFG_KEEP = 8'hC9;
    localparam int unsigned TRIG_W = 5;

    typedef struct packed {
        logic [1:0] trig_code;
        logic [1:0] unused;
        logic       dma;
        logic       tx_clr;
        logic       rx_clr;
        logic       en;
    } fifo_cfg_t;

    typedef struct packed {
        logic rx;
        logic tx;
    } flush_t;

    function automatic logic [TRIG_W-1:0] trig_bytes(input logic [1:0] code);
        logic [TRIG_W-1:0] n;
        case (code)
            2'd0:    n = TRIG_W'(1);
            2'd1:    n = TRIG_W'(4);
            2'd2:    n = TRIG_W'(8);
            default: n = TRIG_W'(14);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/fifo_cfg_reg.sv
module fifo_cfg_reg
    import uart_fifo_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [CFG_W-1:0]     wdata,
    output fifo_cfg_t            cfg,
    output flush_t               flush,
    output logic [TRIG_W-1:0]    trig
);
    fifo_cfg_t wr_cfg;
    logic      toggle;

    assign wr_cfg = fifo_cfg_t'(wdata);
    assign toggle = wr_cfg.en ^ cfg.en;

    always_comb begin
        flush.rx = we & (toggle | wr_cfg.rx_clr);
        flush.tx = we & (toggle | wr_cfg.tx_clr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            cfg <= fifo_cfg_t'(wdata & CFG_KEEP);
        end
    end

    assign trig = trig_bytes(cfg.trig_code);

    // R5: the value after a write is the masked write data
    p_sticky_mask_r5: assert property (@(posedge clk) disable iff (rst)
        we |=> (cfg == fifo_cfg_t'($past(wdata) & CFG_KEEP)));

    // R7: clear bits never survive into the stored value
    p_clr_self_r7: assert property (@(posedge clk) disable iff (rst)
        we |=> (!cfg.rx_clr && !cfg.tx_clr));

endmodule

// File: rtl/byte_ring.sv
module byte_ring #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clr,
    input  logic                          cap_one,
    input  logic                          push,
    input  logic [WIDTH-1:0]              push_data,
    input  logic                          pop,
    output logic [WIDTH-1:0]              pop_data,
    output logic [$clog2(DEPTH+1)-1:0]    count,
    output logic                          push_ok,
    output logic                          pop_ok,
    output logic                          overrun
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH+1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    head, tail;
    logic [CW-1:0]    cap;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
    endfunction

    assign cap     = cap_one ? CW'(1) : CW'(DEPTH);
    assign pop_ok  = pop & (count != '0);
    assign push_ok = push & ((count < cap) | pop_ok);
    assign pop_data = (count != '0) ? mem[tail] : '0;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            head    <= '0;
            tail    <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (push_ok) head <= step(head);
            if (pop_ok)  tail <= step(tail);
            count   <= count + CW'(push_ok) - CW'(pop_ok);
            overrun <= push & ~push_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[head] <= push_data;
    end

    // R2: occupancy never exceeds the depth
    p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R3: a dropped push leaves the occupancy unchanged
    p_drop_keeps_r3: assert property (@(posedge clk) disable iff (rst)
        (push && !push_ok && !pop_ok && !clr) |=> $stable(count));

    // R3: the overflow flag lasts one cycle unless another drop follows
    p_ovr_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        (overrun && !(push && !push_ok)) |=> !overrun);

    // R4: popping an empty queue keeps it empty
    p_empty_pop_r4: assert property (@(posedge clk) disable iff (rst)
        (pop && count == '0 && !push) |=> (count == '0));

endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
    parameter int unsigned CHARS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic cancel,
    input  logic restart,
    input  logic stop,
    input  logic clear_pend,
    input  logic tick,
    input  logic have_data,
    output logic pend
);
    localparam int unsigned TW = $clog2(CHARS+1);

    logic          armed;
    logic [TW-1:0] elapsed;

    always_ff @(posedge clk) begin
        if (rst || cancel) begin
            armed   <= 1'b0;
            elapsed <= '0;
            pend    <= 1'b0;
        end else begin
            if (clear_pend) pend <= 1'b0;
            if (restart) begin
                armed   <= 1'b1;
                elapsed <= '0;
            end else if (stop) begin
                armed   <= 1'b0;
                elapsed <= '0;
            end else if (armed && tick) begin
                if (elapsed == TW'(CHARS-1)) begin
                    armed   <= 1'b0;
                    elapsed <= '0;
                    if (have_data) pend <= 1'b1;
                end else begin
                    elapsed <= elapsed + TW'(1);
                end
            end
        end
    end

    // R12: cancelling drops any pending indication
    p_cancel_drop_r12: assert property (@(posedge clk) disable iff (rst)
        cancel |=> !pend);

    // R11: a host read clears the indication
    p_read_clears_r11: assert property (@(posedge clk) disable iff (rst)
        (clear_pend && !cancel) |=> !pend);

    // R10: the indication only rises on a character tick
    p_rise_on_tick_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(tick));

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
    import uart_fifo_pkg::*;
#(
    parameter int unsigned DEPTH         = 16,
    parameter int unsigned TIMEOUT_CHARS = 4,
    parameter int unsigned CNT_W         = $clog2(DEPTH+1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    output logic              fifo_en,
    output logic              dma_mode,
    output logic [4:0]        trig_level,
    input  logic              rx_push,
    input  logic [7:0]        rx_push_data,
    output logic              rx_overrun,
    input  logic              host_rd,
    output logic [7:0]        host_rd_data,
    output logic [CNT_W-1:0]  rx_count,
    output logic              rx_ready,
    input  logic              host_wr,
    input  logic [7:0]        host_wr_data,
    output logic              tx_overrun,
    input  logic              tx_pop,
    output logic [7:0]        tx_pop_data,
    output logic [CNT_W-1:0]  tx_count,
    input  logic              char_tick,
    output logic              rx_timeout
);
    fifo_cfg_t cfg;
    flush_t    flush;
    logic      rx_push_ok, rx_pop_ok, tx_push_ok, tx_pop_ok;
    logic      tmr_restart, tmr_stop;

    fifo_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .flush (flush),
        .trig  (trig_level)
    );

    byte_ring #(.DEPTH(DEPTH), .WIDTH(8)) u_rx_q (
        .clk       (clk),
        .rst       (rst),
        .clr       (flush.rx),
        .cap_one   (~cfg.en),
        .push      (rx_push),
        .push_data (rx_push_data),
        .pop       (host_rd),
        .pop_data  (host_rd_data),
        .count     (rx_count),
        .push_ok   (rx_push_ok),
        .pop_ok    (rx_pop_ok),
        .overrun   (rx_overrun)
    );

    byte_ring #(.DEPTH(DEPTH), .WIDTH(8)) u_tx_q (
        .clk       (clk),
        .rst       (rst),
        .clr       (flush.tx),
        .cap_one   (~cfg.en),
        .push      (host_wr),
        .push_data (host_wr_data),
        .pop       (tx_pop),
        .pop_data  (tx_pop_data),
        .count     (tx_count),
        .push_ok   (tx_push_ok),
        .pop_ok    (tx_pop_ok),
        .overrun   (tx_overrun)
    );

    assign tmr_restart = cfg.en & (rx_push_ok | (rx_pop_ok & (rx_count > CNT_W'(1))));
    assign tmr_stop    = rx_pop_ok & (rx_count == CNT_W'(1)) & ~rx_push_ok;

    rx_idle_timer #(.CHARS(TIMEOUT_CHARS)) u_idle (
        .clk        (clk),
        .rst        (rst),
        .cancel     (flush.rx),
        .restart    (tmr_restart),
        .stop       (tmr_stop),
        .clear_pend (host_rd),
        .tick       (char_tick),
        .have_data  (rx_count != '0),
        .pend       (rx_timeout)
    );

    assign cfg_rdata = 8'(cfg);
    assign fifo_en   = cfg.en;
    assign dma_mode  = cfg.dma;
    assign rx_ready  = (rx_count != '0);

    // R8: an enable change leaves both queues empty
    p_toggle_flush_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && (cfg_wdata[0] != fifo_en)) |=> (rx_count == '0 && tx_count == '0));

    // R9: single-byte capacity while queueing is off
    p_cap_one_r9: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |-> (rx_count <= CNT_W'(1) && tx_count <= CNT_W'(1)));

    // R10: no idle indication while the receive queue is empty
    p_idle_needs_data_r10: assert property (@(posedge clk) disable iff (rst)
        (rx_timeout && !host_rd && !flush.rx) |-> rx_ready);

endmodule

// File: tb/uart_fifo_ctrl_tb.sv
module uart_fifo_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 0;
    logic [7:0] cfg_wdata = 0;
    logic [7:0] cfg_rdata;
    logic       fifo_en, dma_mode;
    logic [4:0] trig_level;
    logic       rx_push = 0;
    logic [7:0] rx_push_data = 0;
    logic       rx_overrun;
    logic       host_rd = 0;
    logic [7:0] host_rd_data;
    logic [4:0] rx_count;
    logic       rx_ready;
    logic       host_wr = 0;
    logic [7:0] host_wr_data = 0;
    logic       tx_overrun;
    logic       tx_pop = 0;
    logic [7:0] tx_pop_data;
    logic [4:0] tx_count;
    logic       char_tick = 0;
    logic       rx_timeout;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    uart_fifo_ctrl u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .fifo_en(fifo_en), .dma_mode(dma_mode),
        .trig_level(trig_level), .rx_push(rx_push), .rx_push_data(rx_push_data),
        .rx_overrun(rx_overrun), .host_rd(host_rd), .host_rd_data(host_rd_data),
        .rx_count(rx_count), .rx_ready(rx_ready), .host_wr(host_wr),
        .host_wr_data(host_wr_data), .tx_overrun(tx_overrun), .tx_pop(tx_pop),
        .tx_pop_data(tx_pop_data), .tx_count(tx_count), .char_tick(char_tick),
        .rx_timeout(rx_timeout)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] v);
        cfg_we = 1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic rx_in(input logic [7:0] d);
        rx_push = 1; rx_push_data = d;
        @(negedge clk);
        rx_push = 0;
    endtask

    task automatic tx_in(input logic [7:0] d);
        host_wr = 1; host_wr_data = d;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic rx_out(output logic [7:0] d);
        d = host_rd_data;
        host_rd = 1;
        @(negedge clk);
        host_rd = 0;
    endtask

    task automatic tx_out(output logic [7:0] d);
        d = tx_pop_data;
        tx_pop = 1;
        @(negedge clk);
        tx_pop = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            char_tick = 1;
            @(negedge clk);
            char_tick = 0;
        end
    endtask

    function automatic int pat(input int i, input int k);
        return (i * 37 + k * 11 + 5) & 255;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int en_m, rxc, txc, cap, exp_t;

        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 rx_count", rx_count, 0);
        chk("R1 tx_count", tx_count, 0);
        chk("R1 cfg", cfg_rdata, 0);
        chk("R1 trig", trig_level, 1);
        chk("R1 timeout", rx_timeout, 0);
        chk("R1 ready", rx_ready, 0);
        chk("R1 ovr", rx_overrun | tx_overrun, 0);

        // enable queues
        cfg_write(8'h01);
        chk("R5 enable", fifo_en, 1);

        // R2 fill, R3 overflow, R2 drain in order
        for (int i = 0; i < 16; i++) rx_in(8'(pat(i, 0)));
        chk("R2 rx full", rx_count, 16);
        chk("R13 ready", rx_ready, 1);
        rx_in(8'hEE);
        chk("R3 ovr pulse", rx_overrun, 1);
        chk("R3 count kept", rx_count, 16);
        @(negedge clk);
        chk("R3 ovr one cycle", rx_overrun, 0);
        for (int i = 0; i < 16; i++) begin
            rx_out(d);
            chk("R2 rx order", d, pat(i, 0));
        end
        chk("R13 not ready", rx_ready, 0);
        // R4 empty pop
        chk("R4 empty data", host_rd_data, 0);
        rx_out(d);
        chk("R4 empty pop", d, 0);
        chk("R4 count", rx_count, 0);

        // R2 wrap on both queues
        for (int k = 1; k <= 2; k++) begin
            for (int i = 0; i < 10; i++) begin rx_in(8'(pat(i, k))); tx_in(8'(pat(i, k + 5))); end
            for (int i = 0; i < 10; i++) begin
                rx_out(d); chk("R2 rx prewrap", d, pat(i, k));
                tx_out(d); chk("R2 tx prewrap", d, pat(i, k + 5));
            end
            for (int i = 0; i < 16; i++) begin rx_in(8'(pat(i, k + 2))); tx_in(8'(pat(i, k + 7))); end
            chk("R2 tx full", tx_count, 16);
            tx_in(8'h55);
            chk("R3 tx ovr", tx_overrun, 1);
            for (int i = 0; i < 16; i++) begin
                rx_out(d); chk("R2 rx wrap", d, pat(i, k + 2));
                tx_out(d); chk("R2 tx wrap", d, pat(i, k + 7));
            end
            tx_out(d);
            chk("R4 tx empty pop", d, 0);
        end

        // R10 idle timer
        rx_in(8'h11);
        ticks(3);
        chk("R10 not early", rx_timeout, 0);
        ticks(1);
        chk("R10 expiry", rx_timeout, 1);
        rx_out(d);
        chk("R11 read clears", rx_timeout, 0);
        ticks(6);
        chk("R11 stopped when empty", rx_timeout, 0);
        rx_in(8'h21); rx_in(8'h22);
        ticks(4);
        chk("R10 expiry two", rx_timeout, 1);
        rx_out(d);
        chk("R11 clear", rx_timeout, 0);
        ticks(3);
        chk("R11 rearm not early", rx_timeout, 0);
        ticks(1);
        chk("R11 rearm expiry", rx_timeout, 1);
        // R12 clear via config
        rx_in(8'h33);
        cfg_write(8'h03);
        chk("R12 pend dropped", rx_timeout, 0);
        chk("R7 rx cleared", rx_count, 0);
        chk("R7 bit not kept", cfg_rdata, 8'h01);
        rx_in(8'h44);
        ticks(2);
        cfg_write(8'h03);
        ticks(4);
        chk("R12 timer stopped", rx_timeout, 0);
        // R7 tx clear alone
        tx_in(8'h01); rx_in(8'h02);
        cfg_write(8'h05);
        chk("R7 tx cleared", tx_count, 0);
        chk("R7 rx kept", rx_count, 1);
        rx_out(d);

        // R9 disabled capacity
        cfg_write(8'h00);
        rx_in(8'hA1); rx_in(8'hA2);
        chk("R9 rx ovr", rx_overrun, 1);
        chk("R9 rx one", rx_count, 1);
        tx_in(8'hB1); tx_in(8'hB2);
        chk("R9 tx one", tx_count, 1);
        tx_out(d);
        chk("R9 tx data", d, 8'hB1);
        rx_out(d);
        chk("R9 rx data", d, 8'hA1);

        // R5 R6 R8 R9 sweep of every configuration value
        en_m = 0; rxc = 0; txc = 0;
        for (int v = 0; v < 256; v++) begin
            cap = en_m ? 16 : 1;
            rx_in(8'(v)); tx_in(8'(v ^ 8'hFF));
            rxc = (rxc + 1 > cap) ? cap : rxc + 1;
            txc = (txc + 1 > cap) ? cap : txc + 1;
            cfg_write(8'(v));
            if (((v & 1) != en_m) || (v & 2)) rxc = 0;
            if (((v & 1) != en_m) || (v & 4)) txc = 0;
            en_m = v & 1;
            exp_t = ((v >> 6) == 0) ? 1 : ((v >> 6) == 3) ? 14 : 4 * (v >> 6);
            chk("R5 mask", cfg_rdata, v & 8'hC9);
            chk("R5 dma", dma_mode, (v >> 3) & 1);
            chk("R6 trig", trig_level, exp_t);
            chk("R8 rx count", rx_count, rxc);
            chk("R8 tx count", tx_count, txc);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule